// File: doc/BRIEF.md
# ADC Output Conditioning Stage

This block sits between an ADC and a three-state output bus. Each conversion result goes through three steps. First, a floor stage raises any code below a programmed offset up to that offset. Second, a blanking stage forces the code to the offset while the pre-blanking strobe is active. Third, a drive decoder works out whether the bus drivers should be on, using a register bit, an active-low pin and the power-down state.

The conditioned code and the drive enable are registered together, so they reach the pad logic in the same cycle. A separate tap carries the raw conversion result, with no conditioning, to the black-level calibration logic. That tap is unaffected by clipping, clamping, output enable and power-down.

The offset is narrower than the data word and is zero-extended before every comparison or substitution. All comparisons are unsigned.

Top module: `adc_out_cond`

## Requirements
- R1: While `rst_n` is low, `dout` is 0 and `drv_en` is 0.
- R2: When `clip_en` is 1 and the clamp is not in force, the registered `dout` is the unsigned maximum of `adc_code` and the zero-extended `ofs_code`. It is never below that offset.
- R3: When `clip_en` is 0 and the clamp is not in force, `dout` equals `adc_code` from the previous cycle.
- R4: When `clamp_en` is 1 and `blank_i` (active high) is 1, `dout` in the next cycle equals the zero-extended `ofs_code`. This holds whatever the values of `adc_code` and `clip_en`, so the clamp takes priority over the floor.
- R5: When `clamp_en` is 0, `blank_i` has no effect on `dout`.
- R6: `drv_en` in the next cycle is 1 only when `oe_bit` is 1, `oe_pin_n` is 0 and `pwr_dn` is 0. Any other combination drives it to 0, which means the bus is high impedance.
- R7: `dout` keeps tracking the conditioned code while `drv_en` is 0. Output enable and power-down gate only the drive.
- R8: `cal_data` equals `adc_code` in the same cycle, whatever the state of the clip, clamp, output-enable and power-down inputs.
- R9: `dout` and `drv_en` both take exactly one clock cycle of latency from their inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| adc_code | input | DATA_W | Raw conversion result |
| ofs_code | input | OFS_W | Programmed offset code |
| clip_en | input | 1 | Minimum-clip enable |
| clamp_en | input | 1 | Blanking clamp enable |
| blank_i | input | 1 | Pre-blanking strobe, active high |
| oe_bit | input | 1 | Output-enable register bit, active high |
| oe_pin_n | input | 1 | Output-enable pin, active low |
| pwr_dn | input | 1 | Full power-down state |
| dout | output | DATA_W | Registered conditioned code |
| drv_en | output | 1 | Registered bus drive enable |
| cal_data | output | DATA_W | Raw code tap for calibration |

## Verification
The bench builds the block with a 12-bit data word and an 8-bit offset. With these widths, a raw code can fall below, on or above the floor, and both the all-zero offset and the full 255 offset can be paired with the largest 4095 code. That makes the zero-extension and the unsigned comparison visible at the ports. The narrow offset against the wide word also shows that a clamped output never carries upper bits from the raw sample.

// File: rtl/adc_cond_pkg.sv
package adc_cond_pkg;

   typedef enum logic [1:0] {
      SRC_RAW   = 2'd0,
      SRC_FLOOR = 2'd1,
      SRC_OFS   = 2'd2
   } src_sel_e;

   typedef struct packed {
      logic clip_en;
      logic clamp_en;
      logic blank;
   } cond_ctl_t;

endpackage

// File: rtl/adc_floor_stage.sv
module adc_floor_stage #(
   parameter int DATA_W = 12,
   parameter int OFS_W  = 8
) (
   input  logic [DATA_W-1:0] raw_code,
   input  logic [OFS_W-1:0]  ofs_code,
   input  logic              floor_en,
   output logic [DATA_W-1:0] floored,
   output logic              below
);
   localparam int PAD_W = DATA_W - OFS_W;

   logic [DATA_W-1:0] ofs_wide;

   generate
      if (PAD_W > 0) begin : g_pad
         assign ofs_wide = {{PAD_W{1'b0}}, ofs_code};
      end else begin : g_nopad
         assign ofs_wide = ofs_code;
      end
   endgenerate

   always_comb begin
      below   = (raw_code < ofs_wide);
      floored = (floor_en && below) ? ofs_wide : raw_code;
   end
endmodule

// File: rtl/adc_blank_force.sv
module adc_blank_force
   import adc_cond_pkg::*;
#(
   parameter int DATA_W = 12,
   parameter int OFS_W  = 8
) (
   input  cond_ctl_t         ctl,
   input  logic              below,
   output src_sel_e          sel
);
   always_comb begin
      if (ctl.clamp_en && ctl.blank)
         sel = SRC_OFS;
      else if (ctl.clip_en && below)
         sel = SRC_FLOOR;
      else
         sel = SRC_RAW;
   end
endmodule

// File: rtl/adc_drive_ctl.sv
module adc_drive_ctl (
   input  logic oe_bit,
   input  logic oe_pin_n,
   input  logic pwr_dn,
   output logic drive_on
);
   always_comb drive_on = oe_bit & ~oe_pin_n & ~pwr_dn;
endmodule

// File: rtl/adc_out_cond.sv
module adc_out_cond
   import adc_cond_pkg::*;
#(
   parameter int DATA_W = 12,
   parameter int OFS_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] adc_code,
   input  logic [OFS_W-1:0]  ofs_code,
   input  logic              clip_en,
   input  logic              clamp_en,
   input  logic              blank_i,
   input  logic              oe_bit,
   input  logic              oe_pin_n,
   input  logic              pwr_dn,
   output logic [DATA_W-1:0] dout,
   output logic              drv_en,
   output logic [DATA_W-1:0] cal_data
);
   localparam int PAD_W = DATA_W - OFS_W;

   generate
      if (OFS_W < 1 || OFS_W > DATA_W) begin : g_bad_width
         $error("adc_out_cond: OFS_W must be in 1..DATA_W");
      end
   endgenerate

   logic [DATA_W-1:0] floored;
   logic [DATA_W-1:0] ofs_wide;
   logic [DATA_W-1:0] next_code;
   logic              below;
   logic              drive_on;
   src_sel_e          sel;
   cond_ctl_t         ctl;

   generate
      if (PAD_W > 0) begin : g_ofs_pad
         assign ofs_wide = {{PAD_W{1'b0}}, ofs_code};
      end else begin : g_ofs_nopad
         assign ofs_wide = ofs_code;
      end
   endgenerate

   assign ctl = '{clip_en: clip_en, clamp_en: clamp_en, blank: blank_i};

   adc_floor_stage #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_floor (
      .raw_code (adc_code),
      .ofs_code (ofs_code),
      .floor_en (clip_en),
      .floored  (floored),
      .below    (below)
   );

   adc_blank_force #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_force (
      .ctl   (ctl),
      .below (below),
      .sel   (sel)
   );

   adc_drive_ctl u_drive (
      .oe_bit   (oe_bit),
      .oe_pin_n (oe_pin_n),
      .pwr_dn   (pwr_dn),
      .drive_on (drive_on)
   );

   always_comb begin
      unique case (sel)
         SRC_OFS:   next_code = ofs_wide;
         SRC_FLOOR: next_code = floored;
         default:   next_code = adc_code;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout   <= '0;
         drv_en <= 1'b0;
      end else begin
         dout   <= next_code;
         drv_en <= drive_on;
      end
   end

   assign cal_data = adc_code;
endmodule

// File: rtl/adc_out_cond_chk.sv
module adc_out_cond_chk #(
   parameter int DATA_W = 12,
   parameter int OFS_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] adc_code,
   input logic [OFS_W-1:0]  ofs_code,
   input logic              clip_en,
   input logic              clamp_en,
   input logic              blank_i,
   input logic              oe_bit,
   input logic              oe_pin_n,
   input logic              pwr_dn,
   input logic [DATA_W-1:0] dout,
   input logic              drv_en,
   input logic [DATA_W-1:0] cal_data
);
   logic [DATA_W-1:0] ofs_x;
   assign ofs_x = DATA_W'(ofs_code);

   always_comb if (!rst_n) AST_RESET_IDLE: assert (dout == '0 && !drv_en); // R1

   AST_CLAMP_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
      (clamp_en && blank_i) |=> (dout == $past(ofs_x))); // R4

   AST_CLIP_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      (clip_en && !(clamp_en && blank_i)) |=> (dout >= $past(ofs_x) && dout >= $past(adc_code))); // R2

   AST_RAW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (!clip_en && !(clamp_en && blank_i)) |=> (dout == $past(adc_code))); // R3

   AST_DRIVE_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (drv_en == $past(oe_bit && !oe_pin_n && !pwr_dn))); // R6

   AST_PD_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_dn |=> !drv_en); // R6

   AST_CAL_TAP: assert property (@(posedge clk) disable iff (!rst_n)
      cal_data == adc_code); // R8
endmodule

bind adc_out_cond adc_out_cond_chk #(.DATA_W(DATA_W), .OFS_W(OFS_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .adc_code(adc_code), .ofs_code(ofs_code),
   .clip_en(clip_en), .clamp_en(clamp_en), .blank_i(blank_i),
   .oe_bit(oe_bit), .oe_pin_n(oe_pin_n), .pwr_dn(pwr_dn),
   .dout(dout), .drv_en(drv_en), .cal_data(cal_data)
);

// File: tb/adc_out_cond_tb_top.sv
module adc_out_cond_tb_top;
   localparam int DATA_W = 12;
   localparam int OFS_W  = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [DATA_W-1:0] adc_code = '0;
   logic [OFS_W-1:0]  ofs_code = '0;
   logic              clip_en = 1'b1;
   logic              clamp_en = 1'b1;
   logic              blank_i = 1'b0;
   logic              oe_bit = 1'b0;
   logic              oe_pin_n = 1'b1;
   logic              pwr_dn = 1'b0;
   logic [DATA_W-1:0] dout;
   logic              drv_en;
   logic [DATA_W-1:0] cal_data;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   adc_out_cond #(.DATA_W(DATA_W), .OFS_W(OFS_W)) dut_i (.*);

   task automatic chk(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // drive at negedge, let one posedge pass, sample at next negedge
   task automatic apply(input int a, input int o, input bit clip, input bit clamp, input bit blk);
      adc_code = DATA_W'(a); ofs_code = OFS_W'(o);
      clip_en = clip; clamp_en = clamp; blank_i = blk;
      @(posedge clk); @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R1 dout", dout, 0);
      chk("R1 drv_en", 12'(drv_en), 0);
   endtask

   task automatic t_floor();
      apply(10, 40, 1, 1, 0);   chk("R2 below", dout, 40);
      apply(40, 40, 1, 1, 0);   chk("R2 equal", dout, 40);
      apply(41, 40, 1, 1, 0);   chk("R2 above", dout, 41);
      apply(0, 0, 1, 0, 0);     chk("R2 zero ofs", dout, 0);
      apply(4095, 255, 1, 1, 0); chk("R2 max code", dout, 4095);
      apply(254, 255, 1, 1, 0); chk("R2 max ofs", dout, 255);
   endtask

   task automatic t_pass();
      apply(3, 200, 0, 1, 0);   chk("R3 pass low", dout, 3);
      apply(2000, 200, 0, 0, 1); chk("R3 pass high", dout, 2000);
   endtask

   task automatic t_clamp();
      apply(4095, 17, 1, 1, 1); chk("R4 clamp over clip", dout, 17);
      apply(5, 200, 0, 1, 1);   chk("R4 clamp clip off", dout, 200);
      apply(3840, 0, 1, 1, 1);  chk("R4 clamp zero ofs", dout, 0);
   endtask

   task automatic t_blank_ignored();
      apply(1234, 99, 1, 0, 1); chk("R5 blank ignored", dout, 1234);
      apply(7, 99, 0, 0, 1);    chk("R5 blank ignored clip off", dout, 7);
   endtask

   task automatic t_drive();
      for (int i = 0; i < 8; i++) begin
         oe_bit = i[0]; oe_pin_n = i[1]; pwr_dn = i[2];
         @(posedge clk); @(negedge clk);
         chk($sformatf("R6 combo %0d", i), 12'(drv_en), 12'(i == 1));
      end
      oe_bit = 1; oe_pin_n = 0; pwr_dn = 0;
      @(posedge clk); @(negedge clk);
   endtask

   task automatic t_latency();
      oe_bit = 1; oe_pin_n = 0; pwr_dn = 0;
      apply(500, 10, 1, 1, 0);
      adc_code = 900; oe_bit = 0;
      #1;
      chk("R9 dout holds before edge", dout, 500);
      chk("R9 drv holds before edge", 12'(drv_en), 1);
      @(posedge clk); @(negedge clk);
      chk("R9 dout after edge", dout, 900);
      chk("R9 drv after edge", 12'(drv_en), 0);
   endtask

   task automatic t_track_hiz();
      oe_bit = 0; pwr_dn = 1;
      apply(300, 50, 1, 1, 0); chk("R7 tracks while off", dout, 300);
      apply(20, 50, 1, 1, 0);  chk("R7 floor while off", dout, 50);
      chk("R7 drive stays off", 12'(drv_en), 0);
      pwr_dn = 0;
   endtask

   task automatic t_cal();
      adc_code = 12; ofs_code = 200; clip_en = 1; clamp_en = 1; blank_i = 1; pwr_dn = 1;
      #1 chk("R8 raw tap under clamp", cal_data, 12);
      adc_code = 4000; #1 chk("R8 raw tap same cycle", cal_data, 4000);
      pwr_dn = 0; blank_i = 0;
   endtask

   initial begin
      #1;
      t_reset();
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      @(negedge clk);
      t_floor();
      t_pass();
      t_clamp();
      t_blank_ignored();
      t_drive();
      t_latency();
      t_track_hiz();
      t_cal();
      done = 1;
   end

   initial begin
      for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected done");
      end
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule